// File: doc/BRIEF.md
# UART Automatic RTS/CTS Flow Control Unit

This unit sits beside a small UART. It owns the modem-line flow control. It computes the RTS line from the number of free entries left in an 8-entry receive FIFO. It decides when the transmitter may begin the next character, based on a synchronized CTS input. It also holds the receiver and transmitter enables. Software configures it with byte writes to two addresses. Address 0 is an 8-bit control byte. Address 1 holds a software-driven RTS level, used while automatic RTS is off. The FIFOs, shift registers and baud generator live elsewhere. They only exchange a level count, a request/start/done handshake and the two enables with this unit.

Two small state machines do the work. The RTS machine has states `RTS_OPEN` (peer may send) and `RTS_CLOSED`:
- OPEN→CLOSED is taken when free space is at or below the selected threshold.
- CLOSED→OPEN is taken when free space rises above it.

The transmit gate machine has states `TX_IDLE`, `TX_HELD`, `TX_LAUNCH` and `TX_ACTIVE`:
- IDLE→LAUNCH happens on a request while sending is permitted.
- IDLE→HELD happens on a request while sending is not permitted.
- HELD→LAUNCH happens once sending becomes permitted.
- HELD→IDLE happens if the request is withdrawn.
- LAUNCH→ACTIVE is unconditional, after the one-cycle start pulse.
- ACTIVE→IDLE happens on the done strobe.

CTS is ignored while in ACTIVE, so a character that has started always finishes.

Top module: `uart_flow_ctrl`

## Requirements
- R1: After reset the control byte is 0x03, so `rx_enable` and `tx_enable` are 1. The software RTS level is 0, so `rts_out` is 0. `tx_start` is 0.
- R2: A write with `wr_addr`=0 loads the control byte, and its effect appears on the outputs from the following cycle. The control byte fields are: bit0 receiver enable (drives `rx_enable`), bit1 transmitter enable (drives `tx_enable`), bit2 auto-RTS, bit3 auto-CTS, bits5:4 RTS threshold code, bit6 RTS invert, bit7 CTS invert. Cycles without a write leave it unchanged.
- R3: While bit2 is 0, `rts_out` equals bit0 of the last byte written to `wr_addr`=1.
- R4: While bit2 is 1, free space is 8 minus `rx_level`. The threshold code maps 00→3, 01→2, 10→1 and 11→4 entries. One cycle after the level changes, the non-inverted automatic RTS is 1 when free space is above the threshold, and 0 when it is at or below.
- R5: Bit6 inverts the automatic RTS value only. It has no effect on the software RTS value.
- R6: `cts_in` passes through two flops. A change on the pin affects start decisions no sooner than two clock edges later.
- R7: While bit3 is 1, a pending `tx_req` produces a one-cycle `tx_start` only when CTS is asserted. Asserted means the synchronized pin XOR bit7 is 1. Otherwise the request waits and starts once CTS becomes asserted.
- R8: Bit7 inverts the sense of the CTS pin for the auto-CTS decision.
- R9: While bit3 is 0, CTS has no effect on starting a character.
- R10: While `tx_enable` is 0, no `tx_start` is produced.
- R11: After a `tx_start`, no further `tx_start` occurs until `tx_done` has been seen, whatever `tx_req` and CTS do meanwhile.
- R12: With `rx_enable` at 0, automatic RTS still tracks the current `rx_level`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = control byte, 1 = software RTS |
| wr_data | input | 8 | Write data |
| rx_level | input | 4 | Receive FIFO fill count (0..8) |
| cts_in | input | 1 | CTS pin, asynchronous |
| tx_req | input | 1 | Transmitter has a character ready to start |
| tx_done | input | 1 | Transmitter finished the current character |
| rts_out | output | 1 | RTS pin |
| tx_start | output | 1 | One-cycle permission to begin a character |
| rx_enable | output | 1 | Receiver enable |
| tx_enable | output | 1 | Transmitter enable |

## Verification
The bench sweeps every threshold code and invert setting against every fill level from empty to full. This catches a threshold table decoded in plain binary order, and an off-by-one comparison that would drop RTS one entry late or early. It sweeps every combination of auto-CTS, CTS invert, pin level and transmitter enable. A design that skipped the invert, or gated CTS while auto-CTS was off, would start or stall the wrong cases. The release from a held request is timed edge by edge: a missing or extra synchronizer flop moves the start pulse by a cycle. A CTS drop in mid-character and a request held high across a character check that the start is neither repeated nor revoked before the done strobe.

// File: rtl/uart_fc_pkg.sv
package uart_fc_pkg;

    // Control byte; field order follows bit positions 7..0.
    typedef struct packed {
        logic       cts_inv;
        logic       rts_inv;
        logic [1:0] rts_thr;
        logic       auto_cts;
        logic       auto_rts;
        logic       tx_en;
        logic       rx_en;
    } fc_ctrl_t;

    localparam logic [7:0] FC_CTRL_RESET = 8'h03;

    typedef enum logic {
        RTS_OPEN,
        RTS_CLOSED
    } rts_state_e;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_HELD,
        TX_LAUNCH,
        TX_ACTIVE
    } tx_state_e;

    // Non-monotonic threshold encoding: free entries at which RTS drops.
    function automatic logic [2:0] thr_decode(input logic [1:0] code);
        logic [2:0] r;
        unique case (code)
            2'b00:   r = 3'd3;
            2'b01:   r = 3'd2;
            2'b10:   r = 3'd1;
            default: r = 3'd4;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/fc_ctrl_reg.sv
module fc_ctrl_reg
    import uart_fc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       wr_addr,
    input  logic [7:0] wr_data,
    output fc_ctrl_t   ctrl,
    output logic       sw_rts
);

    fc_ctrl_t ctrl_q;
    logic     sw_rts_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= fc_ctrl_t'(FC_CTRL_RESET);
            sw_rts_q <= 1'b0;
        end else if (wr_en) begin
            if (wr_addr == 1'b0) begin
                ctrl_q <= fc_ctrl_t'(wr_data);
            end else begin
                sw_rts_q <= wr_data[0];
            end
        end
    end

    always_comb begin
        ctrl   = ctrl_q;
        sw_rts = sw_rts_q;
    end

    // R2: control byte only changes on a write to address 0
    assert_ctrl_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == 1'b0) |=> $stable(ctrl_q));

endmodule

// File: rtl/fc_rts_gen.sv
module fc_rts_gen
    import uart_fc_pkg::*;
#(
    parameter int RX_DEPTH = 8,
    parameter int LVL_W    = $clog2(RX_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [1:0]       thr_code,
    input  logic             auto_en,
    input  logic             inv,
    input  logic             sw_rts,
    output logic             rts_pin
);

    localparam logic [LVL_W-1:0] DEPTH_V = LVL_W'(RX_DEPTH);

    rts_state_e       state_q, state_d;
    logic [LVL_W-1:0] free_cnt;
    logic [LVL_W-1:0] thr_val;
    logic             at_or_below;

    always_comb begin
        free_cnt    = DEPTH_V - rx_level;
        thr_val     = LVL_W'(thr_decode(thr_code));
        at_or_below = (free_cnt <= thr_val);
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RTS_OPEN:   if (at_or_below)  state_d = RTS_CLOSED;
            RTS_CLOSED: if (!at_or_below) state_d = RTS_OPEN;
            default:    state_d = RTS_OPEN;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RTS_OPEN;
        else        state_q <= state_d;
    end

    // Output process
    always_comb begin
        if (auto_en) rts_pin = (state_q == RTS_OPEN) ^ inv;
        else         rts_pin = sw_rts;
    end

    // R4: a level at or below threshold closes RTS in the next cycle
    assert_rts_closes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (free_cnt <= thr_val) |=> (state_q == RTS_CLOSED));

    // R4: a level above threshold opens RTS in the next cycle
    assert_rts_opens_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (free_cnt > thr_val) |=> (state_q == RTS_OPEN));

    // R12: fill level never exceeds the FIFO depth
    assert_level_range_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rx_level <= DEPTH_V);

endmodule

// File: rtl/fc_tx_gate.sv
module fc_tx_gate
    import uart_fc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cts_pin,
    input  logic auto_cts,
    input  logic cts_inv,
    input  logic tx_en,
    input  logic tx_req,
    input  logic tx_done,
    output logic tx_start
);

    localparam int SYNC_STAGES = 2;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   cts_sync;
    logic                   go_ok;
    tx_state_e              state_q, state_d;
    logic [1:0]             age_q;

    // Two-flop synchronizer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], cts_pin};
    end

    // Cycles since reset, saturating (used by the sync check only)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              age_q <= 2'd0;
        else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
    end

    always_comb begin
        cts_sync = sync_q[SYNC_STAGES-1];
        go_ok    = tx_en && (!auto_cts || (cts_sync ^ cts_inv));
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE: begin
                if (tx_req) state_d = go_ok ? TX_LAUNCH : TX_HELD;
            end
            TX_HELD: begin
                if (!tx_req)    state_d = TX_IDLE;
                else if (go_ok) state_d = TX_LAUNCH;
            end
            TX_LAUNCH: state_d = TX_ACTIVE;
            TX_ACTIVE: begin
                if (tx_done) state_d = TX_IDLE;
            end
            default: state_d = TX_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    // Output process
    always_comb begin
        tx_start = (state_q == TX_LAUNCH);
    end

    // R6: synchronized CTS is the pin value from two edges earlier
    assert_cts_two_flop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        age_q[1] |-> (cts_sync == $past(cts_pin, 2)));

    // R7: a start pulse is only granted after a permitted cycle
    assert_start_permitted_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> $past(go_ok));

    // R11: an active character is never abandoned before done
    assert_char_completes_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_ACTIVE && !tx_done) |=> (state_q == TX_ACTIVE));

    // R11: start is a single-cycle pulse
    assert_start_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |=> !tx_start);

endmodule

// File: rtl/uart_flow_ctrl.sv
module uart_flow_ctrl
    import uart_fc_pkg::*;
#(
    parameter int RX_DEPTH = 8,
    parameter int LVL_W    = $clog2(RX_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [7:0]       wr_data,
    input  logic [LVL_W-1:0] rx_level,
    input  logic             cts_in,
    input  logic             tx_req,
    input  logic             tx_done,
    output logic             rts_out,
    output logic             tx_start,
    output logic             rx_enable,
    output logic             tx_enable
);

    fc_ctrl_t ctrl;
    logic     sw_rts;

    fc_ctrl_reg i_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ctrl    (ctrl),
        .sw_rts  (sw_rts)
    );

    fc_rts_gen #(
        .RX_DEPTH (RX_DEPTH),
        .LVL_W    (LVL_W)
    ) i_rts (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_level (rx_level),
        .thr_code (ctrl.rts_thr),
        .auto_en  (ctrl.auto_rts),
        .inv      (ctrl.rts_inv),
        .sw_rts   (sw_rts),
        .rts_pin  (rts_out)
    );

    fc_tx_gate i_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .cts_pin  (cts_in),
        .auto_cts (ctrl.auto_cts),
        .cts_inv  (ctrl.cts_inv),
        .tx_en    (ctrl.tx_en),
        .tx_req   (tx_req),
        .tx_done  (tx_done),
        .tx_start (tx_start)
    );

    always_comb begin
        rx_enable = ctrl.rx_en;
        tx_enable = ctrl.tx_en;
    end

    // R10: no start pulse while the transmitter was disabled
    assert_no_start_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> $past(tx_enable));

endmodule

// File: tb/test_uart_flow_ctrl.sv
`timescale 1ns/1ps
module test_uart_flow_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_addr = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [3:0] rx_level = 4'd0;
    logic       cts_in = 1'b0;
    logic       tx_req = 1'b0;
    logic       tx_done = 1'b0;
    logic       rts_out, tx_start, rx_enable, tx_enable;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    uart_flow_ctrl i_uart_flow_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rx_level(rx_level), .cts_in(cts_in),
        .tx_req(tx_req), .tx_done(tx_done), .rts_out(rts_out),
        .tx_start(tx_start), .rx_enable(rx_enable), .tx_enable(tx_enable)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic write_reg(input logic a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic int thr_of(input int code);
        case (code)
            0: return 3;
            1: return 2;
            2: return 1;
            default: return 4;
        endcase
    endfunction

    initial begin
        #(4 * 20000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        tick(2);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 rx_enable", rx_enable, 1);
        chk("R1 tx_enable", tx_enable, 1);
        chk("R1 rts_out", rts_out, 0);
        chk("R1 tx_start", tx_start, 0);

        // R3 manual RTS, unaffected by level and by invert (R5)
        rx_level = 4'd8;
        write_reg(1'b1, 8'h01);
        chk("R3 sw rts high", rts_out, 1);
        write_reg(1'b0, 8'h43);
        chk("R5 invert ignored for sw rts", rts_out, 1);
        write_reg(1'b1, 8'h00);
        chk("R3 sw rts low", rts_out, 0);

        // R4/R5/R12 sweep: thresholds x invert x level, rx_en follows thr[0]
        for (int thr = 0; thr < 4; thr++) begin
            for (int inv = 0; inv < 2; inv++) begin
                logic [7:0] c;
                c = {1'b0, inv[0], thr[1:0], 1'b0, 1'b1, 1'b1, thr[0]};
                write_reg(1'b0, c);
                chk("R2/R12 rx_enable", rx_enable, thr[0]);
                for (int lvl = 0; lvl <= 8; lvl++) begin
                    int exp;
                    rx_level = lvl[3:0];
                    tick(1);
                    exp = ((8 - lvl) > thr_of(thr)) ? 1 : 0;
                    exp = exp ^ inv;
                    chk("R4/R5/R12 auto rts", rts_out, exp[7:0]);
                end
                // descending pass checks reopening
                for (int lvl = 8; lvl >= 0; lvl--) begin
                    int exp;
                    rx_level = lvl[3:0];
                    tick(1);
                    exp = (((8 - lvl) > thr_of(thr)) ? 1 : 0) ^ inv;
                    chk("R4 auto rts reopen", rts_out, exp[7:0]);
                end
            end
        end
        rx_level = 4'd0;

        // R7/R8/R9/R10 sweep
        for (int au = 0; au < 2; au++) begin
            for (int ci = 0; ci < 2; ci++) begin
                for (int pin = 0; pin < 2; pin++) begin
                    for (int te = 0; te < 2; te++) begin
                        logic [7:0] c;
                        int exp;
                        c = {ci[0], 1'b0, 2'b00, au[0], 1'b0, te[0], 1'b1};
                        write_reg(1'b0, c);
                        chk("R2 tx_enable", tx_enable, te[7:0]);
                        cts_in = pin[0];
                        tick(3);
                        exp = (te == 1 && (au == 0 || (pin ^ ci) == 1)) ? 1 : 0;
                        tx_req = 1'b1;
                        tick(1);
                        chk("R7/R8/R9/R10 start decision", tx_start, exp[7:0]);
                        tx_req = 1'b0;
                        tick(1);
                        chk("R11 start is one cycle", tx_start, 0);
                        if (exp == 1) begin
                            tx_done = 1'b1;
                            tick(1);
                            tx_done = 1'b0;
                        end
                        tick(1);
                    end
                end
            end
        end

        // R6/R7 held request released by CTS, timed through the synchronizer
        write_reg(1'b0, 8'h0B);
        cts_in = 1'b0;
        tick(3);
        tx_req = 1'b1;
        tick(4);
        chk("R7 held while cts inactive", tx_start, 0);
        cts_in = 1'b1;
        tick(1);
        chk("R6 first sync edge", tx_start, 0);
        tick(1);
        chk("R6 second sync edge", tx_start, 0);
        tick(1);
        chk("R6/R7 start after sync", tx_start, 1);

        // R11: req held, CTS dropped mid-character: no restart before done
        cts_in = 1'b0;
        for (int k = 0; k < 5; k++) begin
            tick(1);
            chk("R11 no start while active", tx_start, 0);
        end
        cts_in = 1'b1;
        tick(3);
        chk("R11 no start before done", tx_start, 0);
        tx_done = 1'b1;
        tick(1);
        tx_done = 1'b0;
        chk("R11 done returns to idle", tx_start, 0);
        tick(1);
        chk("R11 next char after done", tx_start, 1);
        tx_req = 1'b0;
        tick(1);
        tx_done = 1'b1;
        tick(1);
        tx_done = 1'b0;
        tick(2);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule